// File: doc/BRIEF.md
# Binary-Search Trim Calibration Sequencer

This block runs a foreground calibration once each time reset is applied. Before any data conversion takes place, it finds a trim code for the split-capacitor DAC. The code drives a bank of binary-weighted trim capacitors. It is found by successive approximation on a single comparator decision: each trial bit is tested in a two-clock step, and the comparator result decides whether that bit stays set.

A divide-by-two phase clock paces each step. It is made by a toggle flop that is enabled only while calibration runs. A common-mode connect control connects the DAC outputs to common mode during the first clock of each step and floats them during the second clock, when the comparator decides.

After four steps the code is frozen and the done flag rises. Control then passes to the data conversion. Here the conversion is modelled only as a one-cycle start pulse and a fixed busy window.

Top module: `cal_search_seq`

## Requirements
- R1: While reset is high, the in-progress flag is 1, the done flag is 0, the phase clock is 1, the common-mode connect is 1 and the conversion busy flag is 0.
- R2: The search starts from a code with only the top trim bit set (binary 1000 for four bits).
- R3: Each search step spans two clocks. The common-mode connect is 1 in the first clock after reset release and 0 in the second, and this pattern alternates through calibration.
- R4: The comparator is sampled on the falling clock edge inside the second clock of a step. A sampled 0 clears the bit under test and a sampled 1 keeps it. At the next rising edge, the next lower bit is set as the new trial bit.
- R5: When the comparator reports 1 exactly when the trial code is less than or equal to a target, the final code equals that target. A comparator pattern of 0,1,0,1 therefore ends at 0101, and a comparator held at 1 ends at 1111.
- R6: The in-progress flag stays high for exactly 8 clocks after reset release. It falls on the same edge where the done flag rises.
- R7: The phase clock inverts on every clock while calibration is in progress. From the end of calibration onward it stays at 1.
- R8: During calibration, the common-mode connect follows the phase clock. Once done is high, it stays at 0.
- R9: A one-clock conversion start pulse coincides with the rise of done. The conversion busy flag is then high for exactly 14 clocks.
- R10: Reset asserted during calibration or during conversion returns the code to 1000, clears done, raises the in-progress flag and drops conversion busy.
- R11: Once done is high, the comparator input is ignored and the trim code does not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high asynchronous reset; its release starts calibration |
| cmp_in | input | 1 | Comparator decision (1 keeps the bit under test) |
| trim_code | output | TRIM_W | Trim capacitor code, top bit is the heaviest capacitor |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration finished, code frozen |
| phase_clk | output | 1 | Half-rate phase clock, held high outside calibration |
| cm_connect | output | 1 | Connect DAC outputs to common mode |
| conv_start | output | 1 | One-clock pulse starting the data conversion |
| conv_busy | output | 1 | Data conversion window |

## Verification
The bench builds the block with its default parameters: a 4-bit trim code and a 14-clock conversion window. This makes the whole search space small enough to cover exhaustively. A comparator model drives the decision from a hidden target, so every one of the 16 targets is searched. This covers the all-zero and all-one comparator patterns and the alternating 0,1,0,1 case. The short conversion window lets the bench also apply resets in the middle of a search and in the middle of a conversion.

// File: rtl/cal_search_seq.sv
module cal_search_seq #(
  parameter int TRIM_W      = 4,
  parameter int CONV_CYCLES = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_in,
  output logic [TRIM_W-1:0] trim_code,
  output logic              cal_busy,
  output logic              cal_done,
  output logic              phase_clk,
  output logic              cm_connect,
  output logic              conv_start,
  output logic              conv_busy
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [TRIM_W-1:0] TOP_BIT = {1'b1, {(TRIM_W-1){1'b0}}};

  logic [TRIM_W-1:0] trim_q, probe_q, trim_nxt;
  logic              phase_q, busy_q, done_q, cmp_q, start_q;
  logic [CNT_W-1:0]  conv_cnt_q;
  logic              decide;

  assign decide   = busy_q && !phase_q;
  assign trim_nxt = (cmp_q ? trim_q : (trim_q & ~probe_q)) | (probe_q >> 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      trim_q     <= TOP_BIT;
      probe_q    <= TOP_BIT;
      phase_q    <= 1'b1;
      busy_q     <= 1'b1;
      done_q     <= 1'b0;
      start_q    <= 1'b0;
      conv_cnt_q <= '0;
    end else begin
      if (busy_q) phase_q <= ~phase_q;
      start_q <= 1'b0;
      if (conv_cnt_q != '0) conv_cnt_q <= conv_cnt_q - 1'b1;
      if (decide) begin
        trim_q  <= trim_nxt;
        probe_q <= probe_q >> 1;
        if (probe_q[0]) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          start_q    <= 1'b1;
          conv_cnt_q <= CNT_W'(CONV_CYCLES);
        end
      end
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst)         cmp_q <= 1'b0;
    else if (decide) cmp_q <= cmp_in;
  end

  assign trim_code  = trim_q;
  assign cal_busy   = busy_q;
  assign cal_done   = done_q;
  assign phase_clk  = phase_q;
  assign cm_connect = busy_q ? phase_q : ~done_q;
  assign conv_start = start_q;
  assign conv_busy  = conv_cnt_q != '0;
endmodule

module cal_search_seq_chk #(
  parameter int TRIM_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [TRIM_W-1:0] trim_code,
  input logic              cal_busy,
  input logic              cal_done,
  input logic              phase_clk,
  input logic              cm_connect,
  input logic              conv_start
);
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(cal_busy && cal_done));
  p_phase_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    cal_busy |=> phase_clk != $past(phase_clk));
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cal_busy |-> phase_clk);
  p_cm_low_done_r8: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> !cm_connect);
  p_code_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> $stable(trim_code));
  p_start_on_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_done) |-> conv_start);
  p_start_single_r9: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
endmodule

bind cal_search_seq cal_search_seq_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst(rst), .trim_code(trim_code), .cal_busy(cal_busy),
  .cal_done(cal_done), .phase_clk(phase_clk), .cm_connect(cm_connect),
  .conv_start(conv_start)
);

// File: tb/tb_cal_search_seq.sv
`timescale 1ns/1ps
module tb_cal_search_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_in;
  logic [3:0] trim_code;
  logic       cal_busy, cal_done, phase_clk, cm_connect, conv_start, conv_busy;
  logic [3:0] target = 4'd0;
  logic       ovr_en = 1'b0, ovr_val = 1'b0;
  int total = 0, bad = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  assign cmp_in = ovr_en ? ovr_val : (trim_code <= target);

  cal_search_seq dut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .trim_code(trim_code),
    .cal_busy(cal_busy), .cal_done(cal_done), .phase_clk(phase_clk),
    .cm_connect(cm_connect), .conv_start(conv_start), .conv_busy(conv_busy)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  int  busy_cnt = 0, conv_cnt = 0;
  bit  prev_done = 0, prev_conv = 0, cm_bad = 0, ph_bad = 0;
  always @(negedge clk) begin
    if (rst) begin
      busy_cnt = 0; conv_cnt = 0; prev_done = 0; prev_conv = 0;
      cm_bad = 0; ph_bad = 0;
    end else begin
      if (cal_busy) begin
        if (cm_connect != ((busy_cnt % 2) == 0)) cm_bad = 1;   // R3
        if (cm_connect != phase_clk) cm_bad = 1;               // R8
        busy_cnt++;
      end else begin
        if (!phase_clk) ph_bad = 1;                             // R7
        if (cal_done && cm_connect) cm_bad = 1;                 // R8
      end
      if (cal_done && !prev_done) begin
        if (exp_q.size() == 0) check("R5 unexpected done", 1, 0);
        else check("R5 final code", trim_code, exp_q.pop_front());
        check("R6 busy clocks", busy_cnt, 8);
        check("R9 start with done", conv_start, 1);
        check("R3_R8 cm pattern", cm_bad, 0);
      end
      if (conv_busy) conv_cnt++;
      if (prev_conv && !conv_busy) begin
        check("R9 conv clocks", conv_cnt, 14);
        check("R7 phase held", ph_bad, 0);
      end
      prev_done = cal_done;
      prev_conv = conv_busy;
    end
  end

  task automatic run_cal(input int tgt);
    target = 4'(tgt);
    exp_q.push_back(tgt);
    @(posedge clk); #2 rst = 1'b1;
    @(posedge clk); @(posedge clk); #2 rst = 1'b0;
    repeat (26) @(posedge clk);
    #2;
  endtask

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #4;
    check("R1 busy in reset", cal_busy, 1);
    check("R1 done in reset", cal_done, 0);
    check("R1 phase in reset", phase_clk, 1);
    check("R1 cm in reset", cm_connect, 1);
    check("R1 conv busy in reset", conv_busy, 0);
    check("R2 start code", trim_code, 8);

    run_cal(5);   // comparator 0,1,0,1 -> 0101
    run_cal(15);  // comparator always 1 -> 1111
    run_cal(0);   // comparator always 0 -> 0000
    for (int t = 1; t < 15; t++) if (t != 5) run_cal(t);

    // R4: bit under test cleared on 0, next bit set
    target = 4'd3;
    @(posedge clk); #2 rst = 1'b1;
    @(posedge clk); #2 rst = 1'b0;
    repeat (2) @(posedge clk); #2;
    check("R4 after step1", trim_code, 4);
    repeat (2) @(posedge clk); #2;
    check("R4 after step2", trim_code, 2);

    // R10: reset mid calibration
    rst = 1'b1; #1;
    check("R10 code after mid-cal reset", trim_code, 8);
    check("R10 busy after mid-cal reset", cal_busy, 1);
    check("R10 done after mid-cal reset", cal_done, 0);
    run_cal(9);

    // R10: reset mid conversion
    target = 4'd3;
    exp_q.push_back(3);
    @(posedge clk); #2 rst = 1'b1;
    @(posedge clk); #2 rst = 1'b0;
    repeat (12) @(posedge clk); #2;
    check("R9 conv running", conv_busy, 1);
    rst = 1'b1; #1;
    check("R10 done cleared", cal_done, 0);
    check("R10 code after conv reset", trim_code, 8);
    check("R10 conv busy dropped", conv_busy, 0);

    // R11: comparator ignored after done
    run_cal(6);
    ovr_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ovr_val = ~ovr_val;
      @(posedge clk); #2;
    end
    check("R11 code frozen", trim_code, 6);
    check("R11 done held", cal_done, 1);
    ovr_en = 1'b0;

    check("R5 queue drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule